// File: doc/BRIEF.md
# Four-Phase Shared RAM Arbiter

This block lets a CPU and a video fetch unit share one RAM without ever colliding. A free-running two-bit slot counter steps through four slots, one per clock, at the CPU clock rate. The CPU wait line is released only in slot 0. Because of the way the CPU samples its wait line, an opcode fetch lands in slot 0 and an ordinary read or write lands in slot 1. Slots 2 and 3 always belong to video, so video gets two RAM accesses for every four clocks.

On each video turn the block takes one address from the video address generator. It reads the even byte of that address pair in slot 2 and the odd byte in slot 3. The upper address bits are held from slot 2, so the generator may change its output during slot 3. Both bytes are then presented together to the serialiser, along with a one-cycle strobe. The RAM is asynchronous-read: its access must complete within one slot, which a 200 ns part meets at a 4 MHz slot rate.

Top module: `phase_ram_arbiter`

## Requirements
- R1: After synchronous reset (rst_n low) `slot` is 0. It then advances by one every clock, 0,1,2,3,0,... with no dependence on requests.
- R2: `cpu_wait` is low in slot 0 and high in slots 1, 2 and 3.
- R3: An opcode fetch (`cpu_req` = 2'b01) in slot 0 drives `ram_en` high and `ram_addr` = `cpu_addr`. On the next clock `cpu_rdata` takes the RAM byte. A fetch in any other slot is not served.
- R4: A read (`cpu_req` = 2'b10) in slot 1 drives `ram_en` high and `ram_addr` = `cpu_addr`. On the next clock `cpu_rdata` takes the RAM byte. A read in slot 0 is not served.
- R5: `ram_we` is high only in slot 1 with `cpu_req` = 2'b11. In that cycle it drives `ram_addr` = `cpu_addr` and `ram_wdata` = `cpu_wdata`. A write leaves `cpu_rdata` unchanged.
- R6: In slot 2, `ram_addr` = {`vid_addr`[AW-1:1], 0}. In slot 3, `ram_addr` = {the upper bits captured in slot 2, 1}. `ram_en` is high in both slots.
- R7: On the clock that ends slot 3, `vid_byte0` gets the slot-2 byte and `vid_byte1` gets the slot-3 byte. `vid_valid` is high for exactly the one following cycle, which is slot 0.
- R8: While reset is held, `cpu_wait`, `vid_valid`, `cpu_rdata`, `vid_byte0` and `vid_byte1` are 0.
- R9: In slots 2 and 3, CPU requests of any type do not write RAM and do not change `cpu_rdata`. With `cpu_req` = 2'b00 (idle), no CPU access is made in any slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slot clock (CPU clock rate) |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_req | input | 2 | 00 idle, 01 opcode fetch, 10 read, 11 write |
| cpu_addr | input | AW | CPU byte address |
| cpu_wdata | input | DW | CPU write data |
| cpu_wait | output | 1 | Wait line to the CPU |
| cpu_rdata | output | DW | Last byte read for the CPU |
| vid_addr | input | AW | Address from the video address generator |
| vid_byte0 | output | DW | Even-address video byte |
| vid_byte1 | output | DW | Odd-address video byte |
| vid_valid | output | 1 | One-cycle strobe for the byte pair |
| ram_addr | output | AW | RAM address |
| ram_wdata | output | DW | RAM write data |
| ram_rdata | input | DW | RAM read data (asynchronous) |
| ram_en | output | 1 | RAM access active this cycle |
| ram_we | output | 1 | RAM write strobe |
| slot | output | 2 | Current slot number |

## Verification
Two functions can fall in the same cycle. One is the delivery of a finished video pair, with its strobe, in slot 0. The other is a CPU opcode fetch in that same slot 0, which loads `cpu_rdata` at the next edge. The sweep rotates the request type through the slots frame by frame, so every frame that is followed by a fetch overlaps the two. Both outputs are judged on the same sampling point against a bench copy of RAM. Writes from the previous slot 1 shift that copy, so a wrong slot for either function shows up as a stale or misplaced byte.

// File: rtl/phase_ram_arbiter.sv
module phase_ram_arbiter #(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    cpu_req,
  input  logic [AW-1:0] cpu_addr,
  input  logic [DW-1:0] cpu_wdata,
  output logic          cpu_wait,
  output logic [DW-1:0] cpu_rdata,
  input  logic [AW-1:0] vid_addr,
  output logic [DW-1:0] vid_byte0,
  output logic [DW-1:0] vid_byte1,
  output logic          vid_valid,
  output logic [AW-1:0] ram_addr,
  output logic [DW-1:0] ram_wdata,
  input  logic [DW-1:0] ram_rdata,
  output logic          ram_en,
  output logic          ram_we,
  output logic [1:0]    slot
);

  localparam logic [1:0] REQ_FETCH = 2'b01;

  logic [1:0]    ph;
  logic [AW-2:0] vhi_q;
  logic [DW-1:0] vb0_q;

  wire fetch_hit = (ph == 2'd0) && (cpu_req == REQ_FETCH);
  wire data_hit  = (ph == 2'd1) && cpu_req[1];
  wire vid_turn  = ph[1];

  assign slot      = ph;
  assign cpu_wait  = rst_n && (ph != 2'd0);
  assign ram_en    = fetch_hit || data_hit || vid_turn;
  assign ram_we    = data_hit && cpu_req[0];
  assign ram_wdata = cpu_wdata;
  assign ram_addr  = !vid_turn ? cpu_addr :
                     ph[0]     ? {vhi_q, 1'b1} : {vid_addr[AW-1:1], 1'b0};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph        <= 2'd0;
      vhi_q     <= '0;
      vb0_q     <= '0;
      cpu_rdata <= '0;
      vid_byte0 <= '0;
      vid_byte1 <= '0;
      vid_valid <= 1'b0;
    end else begin
      ph        <= ph + 2'd1;
      vid_valid <= (ph == 2'd3);
      if ((fetch_hit || data_hit) && !ram_we) cpu_rdata <= ram_rdata;
      if (ph == 2'd2) begin
        vhi_q <= vid_addr[AW-1:1];
        vb0_q <= ram_rdata;
      end
      if (ph == 2'd3) begin
        vid_byte0 <= vb0_q;
        vid_byte1 <= ram_rdata;
      end
    end
  end

  a_r1_slot_step: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> slot == $past(slot) + 2'd1);
  a_r2_wait_release: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cpu_wait) |-> slot == 2'd0);
  a_r5_write_slot: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> slot == 2'd1 && cpu_req == 2'b11);
  a_r9_video_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_en && slot[1]) |-> !ram_we);
  a_r6_odd_byte: assert property (@(posedge clk) disable iff (!rst_n)
    slot == 2'd3 |-> ram_en && ram_addr[0]);
  a_r7_strobe_slot: assert property (@(posedge clk) disable iff (!rst_n)
    vid_valid |-> slot == 2'd0 && !$past(vid_valid));

endmodule

// File: tb/sim_phase_ram_arbiter.sv
`timescale 1ns/1ps
module sim_phase_ram_arbiter;
  localparam int AW = 8;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] cpu_req = 2'b00;
  logic [AW-1:0] cpu_addr = '0, vid_addr = '0;
  logic [DW-1:0] cpu_wdata = '0;
  logic cpu_wait, vid_valid, ram_en, ram_we;
  logic [DW-1:0] cpu_rdata, vid_byte0, vid_byte1, ram_wdata, ram_rdata;
  logic [AW-1:0] ram_addr;
  logic [1:0] slot;

  logic [7:0] mem [256];
  logic [7:0] ref_m [256];
  int total = 0, bad = 0;
  logic [7:0] exp_rd = 8'h00, exp_b0 = 8'h00, exp_b1 = 8'h00, pend_b0 = 8'h00;
  logic [6:0] vhi = 7'h00;
  logic exp_valid = 1'b0;

  always #2 clk = ~clk;

  phase_ram_arbiter #(.AW(AW), .DW(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_wait(cpu_wait), .cpu_rdata(cpu_rdata),
    .vid_addr(vid_addr), .vid_byte0(vid_byte0), .vid_byte1(vid_byte1),
    .vid_valid(vid_valid), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
    .ram_rdata(ram_rdata), .ram_en(ram_en), .ram_we(ram_we), .slot(slot));

  assign ram_rdata = mem[ram_addr];
  always @(posedge clk) if (ram_we) mem[ram_addr] <= ram_wdata;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input int s, input logic [1:0] rq, input logic [7:0] a,
                      input logic [7:0] wd, input logic [7:0] va);
    logic en, we;
    logic [7:0] ea;
    cpu_req = rq; cpu_addr = a; cpu_wdata = wd; vid_addr = va;
    #1;
    chk("R1 slot", slot, s);
    chk("R2 wait", cpu_wait, s != 0);
    en = (s == 0 && rq == 2'b01) || (s == 1 && rq[1]) || s >= 2;
    we = (s == 1 && rq == 2'b11);
    ea = (s == 2) ? {va[7:1], 1'b0} : (s == 3) ? {vhi, 1'b1} : a;
    chk(s >= 2 ? "R9 ram_en" : "R3/R4 ram_en", ram_en, en);
    chk("R5/R9 ram_we", ram_we, we);
    if (en) chk(s >= 2 ? "R6 ram_addr" : "R3/R4 ram_addr", ram_addr, ea);
    if (we) chk("R5 ram_wdata", ram_wdata, wd);
    if (s == 0 && rq == 2'b01) exp_rd = ref_m[a];
    if (s == 1 && rq == 2'b10) exp_rd = ref_m[a];
    if (we) ref_m[a] = wd;
    if (s == 2) begin vhi = va[7:1]; pend_b0 = ref_m[{va[7:1], 1'b0}]; end
    if (s == 3) begin exp_b0 = pend_b0; exp_b1 = ref_m[{vhi, 1'b1}]; end
    exp_valid = (s == 3);
    @(posedge clk);
    @(negedge clk);
    chk("R3/R4/R5/R9 cpu_rdata", cpu_rdata, exp_rd);
    chk("R7 vid_valid", vid_valid, exp_valid);
    if (exp_valid) begin
      chk("R7 vid_byte0", vid_byte0, exp_b0);
      chk("R7 vid_byte1", vid_byte1, exp_b1);
    end
  endtask

  initial begin
    #200000;
    total++; bad++;
    $display("FAIL R1 watchdog actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) begin
      mem[i] = 8'(i * 3 + 1);
      ref_m[i] = 8'(i * 3 + 1);
    end
    repeat (3) @(negedge clk);
    chk("R8 slot", slot, 0);
    chk("R8 wait", cpu_wait, 0);
    chk("R8 vid_valid", vid_valid, 0);
    chk("R8 cpu_rdata", cpu_rdata, 0);
    chk("R8 vid_bytes", {vid_byte0, vid_byte1}, 0);
    rst_n = 1'b1;
    for (int f = 0; f < 400; f++) begin
      for (int s = 0; s < 4; s++) begin
        step(s, 2'((f * 3 + s * 5) % 4), 8'((f * 37 + s * 11) % 256),
             8'(f * 7 + s), 8'((f * 13 + s * 29) % 256));
      end
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule